// File: doc/BRIEF.md
# Prioritized Interrupt Selection Controller

This block chooses which of a set of external interrupt lines the processor core should take next. Every line has a programmable 8-bit urgency value, where a smaller number is more urgent, and an enable bit. A request is pending when its level input is asserted or when software sets it through the configuration port. Among the enabled pending lines whose urgency value is strictly below the core's current execution priority, the block picks the most urgent one. It reports that line's global exception number and raises a one-cycle take strobe.

Exception numbers below 16 belong to system exceptions. External line k is therefore reported as exception 16 + k. Software writes priorities and enables, and sets or clears pending requests, through a single write port. The port carries an operation code, a line index and a data byte.

A two-state controller arbitrates. In `ST_ARMED` it evaluates the eligible lines every cycle. When a winner exists it registers the exception number, clears the winner's pending bit and moves to `ST_FIRE` (transition *arm-to-fire*). `ST_FIRE` is the cycle in which the take strobe is high. From there the controller always returns to `ST_ARMED` (transition *fire-to-arm*), so at least one quiet cycle separates two takes. When no line is eligible, `ST_ARMED` stays where it is (transition *arm-hold*).

Top module: `prio_irq_select`

## Requirements
- R1: Among eligible lines, the one with the numerically smallest priority value (0 to 255) is taken. Priorities are written with operation code 0 (`cfg_op` = 0), with the line in `cfg_line` and the value in `cfg_data`.
- R2: When eligible lines have equal priority values, the line with the lower index, and so the lower exception number, is taken first.
- R3: `exc_num` equals 16 + k while `take_exc` is high for line k, and is 0 whenever `take_exc` is low.
- R4: A line is eligible only while its enable bit is set. The enable bit is written with operation code 1, taking `cfg_data[0]`. A disabled pending line stays pending and is taken once it is enabled.
- R5: A line is eligible only if its priority value is strictly less than `cur_prio`. `cur_prio` is 9 bits wide, so the value 256 lets every priority through and 0 blocks all lines.
- R6: `take_exc` is registered. It is high for exactly one cycle, in the cycle after the first edge at which the winning line is pending, and at least one low cycle follows it. The taken line's pending bit is cleared at the same edge, so a single request is taken once.
- R7: Every cycle that a line's `irq_level` bit is high sets its pending bit. The bit stays set after the level drops, and a level held high re-pends the line after each take.
- R8: A write with operation code 2 sets the addressed line's pending bit.
- R9: A write with operation code 3 clears the addressed line's pending bit and keeps that line out of arbitration in the same cycle. It has no lasting effect while the line's level input is high.
- R10: After reset there are no pending requests, every line is disabled, every priority is 0, `take_exc` is low and `exc_num` is 0.
- R11: Configuration writes whose line index is not below the number of lines change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Operation: 0 priority, 1 enable, 2 set pending, 3 clear pending |
| cfg_line | input | LINE_W | Target line index |
| cfg_data | input | PRIO_W | Priority value, or enable in bit 0 |
| irq_level | input | NUM_LINES | Level request per line |
| cur_prio | input | PRIO_W+1 | Current execution priority of the core |
| take_exc | output | 1 | One-cycle take strobe |
| exc_num | output | EXC_W | Global exception number of the taken line |

## Verification
The bench builds the block with six lines and 8-bit priorities. Six lines are few enough to sweep all 63 non-empty request patterns twice, once under a priority set full of ties and once under a strictly ordered set that includes 255. Each sweep drains the lines and checks the full take order and the spacing of the takes against an arithmetic model. Six is not a power of two, so the padded leaves of the selection tree are exercised. The 3-bit line index can also address the nonexistent lines 6 and 7, which brings the ignored-write case within reach.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

    // Configuration operation codes carried on cfg_op
    typedef enum logic [1:0] {
        OP_PRIO    = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_SETPEND = 2'd2,
        OP_CLRPEND = 2'd3
    } cfg_op_e;

    // Arbitration controller states
    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_FIRE  = 1'b1
    } sel_state_e;

    // Exception numbers reserved ahead of the first external line
    localparam int unsigned SYS_EXC_COUNT = 16;

endpackage

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LINES-1:0]              wr_prio,
    input  logic [NUM_LINES-1:0]              wr_enable,
    input  logic [PRIO_W-1:0]                 wr_data,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_flat,
    output logic [NUM_LINES-1:0]              en_vec
);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_flat[k] <= '0;
                en_vec[k]    <= 1'b0;
            end else begin
                if (wr_prio[k]) begin
                    prio_flat[k] <= wr_data;
                end
                if (wr_enable[k]) begin
                    en_vec[k] <= wr_data[0];
                end
            end
        end
    end

endmodule

// File: rtl/prio_pend_tracker.sv
module prio_pend_tracker #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level_in,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] sw_clr,
    input  logic [NUM_LINES-1:0] taken,
    output logic [NUM_LINES-1:0] pend_vec
);

    logic [NUM_LINES-1:0] pend_next;

    // Clears (software or take) act first; level and software sets win over them.
    always_comb begin
        pend_next = (pend_vec & ~sw_clr & ~taken) | level_in | sw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vec <= '0;
        end else begin
            pend_vec <= pend_next;
        end
    end

endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             elig,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic                             win_valid,
    output logic [LINE_W-1:0]                win_idx
);

    localparam int LEAVES = 1 << LINE_W;

    // Tournament tree: level 0 holds the leaves, level LINE_W the root.
    for (genvar lv = 0; lv <= LINE_W; lv++) begin : g_lvl
        localparam int CNT = LEAVES >> lv;
        logic [CNT-1:0]             v;
        logic [CNT-1:0][PRIO_W-1:0] p;
        logic [CNT-1:0][LINE_W-1:0] ix;

        for (genvar j = 0; j < CNT; j++) begin : g_node
            if (lv == 0) begin : g_leaf
                if (j < NUM_LINES) begin : g_real
                    assign v[j] = elig[j];
                    assign p[j] = prio[j];
                end else begin : g_pad
                    assign v[j] = 1'b0;
                    assign p[j] = '1;
                end
                assign ix[j] = LINE_W'(j);
            end else begin : g_cmp
                logic pick_left;
                // Left child carries the lower indices, so it keeps ties.
                assign pick_left = g_lvl[lv-1].v[2*j] &&
                                   (!g_lvl[lv-1].v[2*j+1] ||
                                    (g_lvl[lv-1].p[2*j] <= g_lvl[lv-1].p[2*j+1]));
                assign v[j]  = g_lvl[lv-1].v[2*j] | g_lvl[lv-1].v[2*j+1];
                assign p[j]  = pick_left ? g_lvl[lv-1].p[2*j]  : g_lvl[lv-1].p[2*j+1];
                assign ix[j] = pick_left ? g_lvl[lv-1].ix[2*j] : g_lvl[lv-1].ix[2*j+1];
            end
        end
    end

    assign win_valid = g_lvl[LINE_W].v[0];
    assign win_idx   = g_lvl[LINE_W].ix[0];

endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select
    import prio_sel_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 8,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int EXC_W    = $clog2(SYS_EXC_COUNT + NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_op,
    input  logic [LINE_W-1:0]    cfg_line,
    input  logic [PRIO_W-1:0]    cfg_data,
    input  logic [NUM_LINES-1:0] irq_level,
    input  logic [PRIO_W:0]      cur_prio,
    output logic                 take_exc,
    output logic [EXC_W-1:0]     exc_num
);

    cfg_op_e                        op;
    logic [NUM_LINES-1:0]           line_oh;
    logic [NUM_LINES-1:0]           wr_prio_mask;
    logic [NUM_LINES-1:0]           wr_en_mask;
    logic [NUM_LINES-1:0]           set_mask;
    logic [NUM_LINES-1:0]           clr_mask;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_flat;
    logic [NUM_LINES-1:0]           en_vec;
    logic [NUM_LINES-1:0]           pend_vec;
    logic [NUM_LINES-1:0]           elig;
    logic [NUM_LINES-1:0]           take_mask;
    logic                           win_valid;
    logic [LINE_W-1:0]              win_idx;
    logic                           take_fire;
    sel_state_e                     state_q;
    sel_state_e                     state_d;
    logic [EXC_W-1:0]               exc_q;

    assign op = cfg_op_e'(cfg_op);

    // Line decode: an index past the last line selects nothing.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_dec
        assign line_oh[k] = cfg_we && (cfg_line == LINE_W'(k));
    end

    always_comb begin
        wr_prio_mask = '0;
        wr_en_mask   = '0;
        set_mask     = '0;
        clr_mask     = '0;
        unique case (op)
            OP_PRIO:    wr_prio_mask = line_oh;
            OP_ENABLE:  wr_en_mask   = line_oh;
            OP_SETPEND: set_mask     = line_oh;
            OP_CLRPEND: clr_mask     = line_oh;
        endcase
    end

    prio_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_prio   (wr_prio_mask),
        .wr_enable (wr_en_mask),
        .wr_data   (cfg_data),
        .prio_flat (prio_flat),
        .en_vec    (en_vec)
    );

    prio_pend_tracker #(
        .NUM_LINES (NUM_LINES)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (irq_level),
        .sw_set   (set_mask),
        .sw_clr   (clr_mask),
        .taken    (take_mask),
        .pend_vec (pend_vec)
    );

    // Eligibility: pending, enabled, below running priority, not being cleared now.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_elig
        assign elig[k] = pend_vec[k] && en_vec[k] && !clr_mask[k] &&
                         ({1'b0, prio_flat[k]} < cur_prio);
    end

    prio_tree #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W)
    ) u_tree (
        .elig      (elig),
        .prio      (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    assign take_fire = (state_q == ST_ARMED) && win_valid;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_take
        assign take_mask[k] = take_fire && (win_idx == LINE_W'(k));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm-hold, arm-to-fire, fire-to-arm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (win_valid) state_d = ST_FIRE;
            ST_FIRE:  state_d = ST_ARMED;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= '0;
        end else if (take_fire) begin
            exc_q <= EXC_W'(SYS_EXC_COUNT) + EXC_W'(win_idx);
        end else begin
            exc_q <= '0;
        end
    end

    assign take_exc = (state_q == ST_FIRE);
    assign exc_num  = exc_q;

endmodule

// File: rtl/prio_irq_select_chk.sv
module prio_irq_select_chk #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 8,
    parameter int LINE_W    = 5,
    parameter int EXC_W     = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             take_exc,
    input logic [EXC_W-1:0]                 exc_num,
    input logic [PRIO_W:0]                  cur_prio,
    input logic [NUM_LINES-1:0]             irq_level,
    input logic [NUM_LINES-1:0]             clr_mask,
    input logic [NUM_LINES-1:0]             en_vec,
    input logic [NUM_LINES-1:0]             pend_vec,
    input logic [NUM_LINES-1:0][PRIO_W-1:0] prio_flat
);

    logic [NUM_LINES-1:0]             p_en, p_pend, p_lvl, p_clr;
    logic [NUM_LINES-1:0][PRIO_W-1:0] p_prio;
    logic [PRIO_W:0]                  p_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_en   <= '0;
            p_pend <= '0;
            p_lvl  <= '0;
            p_clr  <= '0;
            p_prio <= '0;
            p_cur  <= '0;
        end else begin
            p_en   <= en_vec;
            p_pend <= pend_vec;
            p_lvl  <= irq_level;
            p_clr  <= clr_mask;
            p_prio <= prio_flat;
            p_cur  <= cur_prio;
        end
    end

    int          idx_i;
    logic        t_en, t_pend, t_lvl, t_now;
    logic [PRIO_W-1:0] t_prio;
    logic        better_exists;

    always_comb begin
        idx_i  = int'(exc_num) - 16;
        t_en   = 1'b0;
        t_pend = 1'b0;
        t_lvl  = 1'b0;
        t_now  = 1'b0;
        t_prio = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (k == idx_i) begin
                t_en   = p_en[k];
                t_pend = p_pend[k];
                t_lvl  = p_lvl[k];
                t_now  = pend_vec[k];
                t_prio = p_prio[k];
            end
        end
        better_exists = 1'b0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (p_pend[k] && p_en[k] && !p_clr[k] && ({1'b0, p_prio[k]} < p_cur) &&
                ((p_prio[k] < t_prio) || ((p_prio[k] == t_prio) && (k < idx_i)))) begin
                better_exists = 1'b1;
            end
        end
    end

    p_take_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> !take_exc);

    p_idle_num_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |-> (exc_num == '0));

    p_num_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> ((idx_i >= 0) && (idx_i < NUM_LINES)));

    p_taken_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> t_en);

    p_taken_was_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> t_pend);

    p_taken_beats_cur_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> ({1'b0, t_prio} < p_cur));

    p_taken_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (!t_now || t_lvl));

    // Covers R2 as well: ties must resolve toward the lower line
    p_best_choice_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> !better_exists);

endmodule

bind prio_irq_select prio_irq_select_chk #(
    .NUM_LINES (NUM_LINES),
    .PRIO_W    (PRIO_W),
    .LINE_W    (LINE_W),
    .EXC_W     (EXC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_exc  (take_exc),
    .exc_num   (exc_num),
    .cur_prio  (cur_prio),
    .irq_level (irq_level),
    .clr_mask  (clr_mask),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec),
    .prio_flat (prio_flat)
);

// File: tb/test_prio_irq_select.sv
module test_prio_irq_select;

    localparam int  N  = 6;
    localparam int  PW = 8;
    localparam int  LW = 3;
    localparam int  EW = 5;
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [LW-1:0] cfg_line = '0;
    logic [PW-1:0] cfg_data = '0;
    logic [N-1:0]  irq_level = '0;
    logic [PW:0]   cur_prio = 9'd256;
    logic          take_exc;
    logic [EW-1:0] exc_num;

    prio_irq_select #(.NUM_LINES(N), .PRIO_W(PW)) i_prio_irq_select (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_line(cfg_line), .cfg_data(cfg_data), .irq_level(irq_level),
        .cur_prio(cur_prio), .take_exc(take_exc), .exc_num(exc_num)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int model_prio[N];
    bit model_en[N];
    int got[16];
    int pos[16];
    int ngot;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int op, input int line, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = 2'(op); cfg_line = LW'(line); cfg_data = PW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic collect(input int n);
        ngot = 0;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            if (take_exc) begin
                if (ngot < 16) begin
                    got[ngot] = int'(exc_num);
                    pos[ngot] = c;
                end
                ngot++;
            end
        end
    endtask

    task automatic clear_all();
        for (int k = 0; k < N; k++) cfg(3, k, 0);
    endtask

    // Pulse the level inputs for one cycle, drain, compare the full take order.
    task automatic pulse_check(input int mask, input int cur, input string req);
        int  e[N];
        int  ne;
        bit  used[N];
        cur_prio = 9'(cur);
        @(negedge clk); irq_level = N'(mask);
        @(negedge clk); irq_level = '0;
        collect(2*N + 4);
        ne = 0;
        for (int k = 0; k < N; k++) used[k] = 1'b0;
        for (int r = 0; r < N; r++) begin
            int best;
            best = -1;
            for (int k = 0; k < N; k++) begin
                if (mask[k] && model_en[k] && (model_prio[k] < cur) && !used[k]) begin
                    if (best < 0 || model_prio[k] < model_prio[best]) best = k;
                end
            end
            if (best >= 0) begin
                used[best] = 1'b1;
                e[ne] = best;
                ne++;
            end
        end
        chk(ngot == ne, req, $sformatf("take count mask=%0d cur=%0d", mask, cur), ngot, ne);
        for (int i = 0; i < ne && i < ngot; i++) begin
            chk(got[i] == 16 + e[i], req, $sformatf("R3 exc_num #%0d mask=%0d", i, mask), got[i], 16 + e[i]);
            chk(pos[i] == 1 + 2*i, "R6", $sformatf("take cycle #%0d mask=%0d", i, mask), pos[i], 1 + 2*i);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin model_prio[k] = 0; model_en[k] = 1'b0; end
        repeat (3) @(negedge clk);
        chk(take_exc == 1'b0, "R10", "take_exc in reset", int'(take_exc), 0);
        chk(exc_num == '0, "R10", "exc_num in reset", int'(exc_num), 0);
        rst_n = 1'b1;

        // R10: all lines disabled after reset, so nothing is taken
        pulse_check(63, 256, "R10");
        clear_all();

        // Priority set with ties (R1, R2)
        for (int k = 0; k < N; k++) begin
            model_prio[k] = ((k * 3) % 4) * 16;
            model_en[k] = 1'b1;
            cfg(0, k, model_prio[k]);
            cfg(1, k, 1);
        end
        for (int m = 1; m < 64; m++) pulse_check(m, 256, "R2");

        // R5: running priority threshold sweep, then R9 clears of the leftovers
        begin
            int curs[7] = '{0, 1, 16, 17, 48, 49, 256};
            for (int i = 0; i < 7; i++) begin
                pulse_check(63, curs[i], "R5");
                clear_all();
                cur_prio = 9'd256;
                collect(8);
                chk(ngot == 0, "R9", $sformatf("takes after clearing cur=%0d", curs[i]), ngot, 0);
            end
        end

        // Strictly ordered set including 255 (R1)
        for (int k = 0; k < N; k++) begin
            model_prio[k] = 255 - k * 40;
            cfg(0, k, model_prio[k]);
        end
        for (int m = 1; m < 64; m++) pulse_check(m, 256, "R1");

        // R4: disabled line stays pending, taken once enabled
        model_en[5] = 1'b0;
        cfg(1, 5, 0);
        pulse_check(63, 256, "R4");
        model_en[5] = 1'b1;
        cfg(1, 5, 1);
        collect(6);
        chk(ngot == 1, "R4", "takes after enable", ngot, 1);
        chk(got[0] == 21, "R4", "exc_num after enable", got[0], 21);

        // R8: software set-pending
        cfg(2, 2, 0);
        collect(6);
        chk(ngot == 1, "R8", "takes after set-pending", ngot, 1);
        chk(got[0] == 18, "R8", "exc_num after set-pending", got[0], 18);

        // R9: clear before the request can be taken
        cur_prio = 9'd0;
        cfg(2, 1, 0);
        cfg(3, 1, 0);
        cur_prio = 9'd256;
        collect(8);
        chk(ngot == 0, "R9", "takes after clear-pending", ngot, 0);

        // R11: writes to indexes 6 and 7 do nothing
        cfg(2, 6, 0);
        cfg(2, 7, 0);
        cfg(1, 7, 0);
        collect(6);
        chk(ngot == 0, "R11", "takes after out-of-range writes", ngot, 0);
        pulse_check(63, 256, "R11");

        // R7: level held high re-pends after each take
        @(negedge clk); irq_level = N'(1 << 3);
        collect(8);
        chk(ngot == 4, "R7", "takes with level held", ngot, 4);
        for (int i = 0; i < 4 && i < ngot; i++)
            chk(got[i] == 19, "R7", "exc_num with level held", got[i], 19);
        cfg(3, 3, 0);
        collect(6);
        chk(ngot >= 2, "R9", "takes continue after clear while level high", ngot, 3);
        @(negedge clk); irq_level = '0;
        collect(4);
        clear_all();
        collect(6);
        chk(ngot == 0, "R9", "takes after level dropped and cleared", ngot, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule